// File: doc/BRIEF.md
# Calendar Real-Time Clock with One-Shot Alarm

This block is a register-mapped wall clock. A slow reference enable, typically 32768 pulses per second, is divided by a parameterised prescaler into a one-second tick. On each tick the calendar advances second, minute, hour, weekday, day of month, month and a two-digit year. Day-of-month rollover follows the month length, and February has 29 days in leap years. A second bank holds an alarm time. When the calendar reaches the alarm time, it sets a sticky pending flag, and that flag drives an interrupt line.

Software reaches the block through a plain 32-bit write port and a combinational read port, both addressed by byte. Writes to the calendar, the alarm bank, the run control and the alarm arming register have no effect until software writes a fixed seven-step key sequence to the unlock window. Software stops the clock, loads the fields, then restarts it. Because every field changes on the same clock edge, a reader can fetch the seconds field first and last and repeat the read if the two values differ.

Top module: `cal_rtc_top`

## Requirements
- R1: After reset, the time fields read year 0, month 1, day of month 1, weekday 0, hour 0, minute 0 and second 0. The run-control register at 0x20 reads 1 (stop bit, bit 0, set). Status at 0x30 reads 0, the irq output is low, and the glitch-filter register at 0x2c reads 0.
- R2: While the block is locked, writes to time fields (0x40 to 0x58), alarm fields (0x60 to 0x78), run control (0x20) and alarm arming (0x7c) leave those registers unchanged.
- R3: The block unlocks only after seven consecutive writes in the window 0x04 to 0x1c, in address order: 0xc6 to 0x04, 0x9a to 0x08, 0x59 to 0x0c, 0xa3 to 0x10, 0x57 to 0x14, 0x67 to 0x18 and 0xd2 to 0x1c. Any other write in that window restarts the sequence.
- R4: While running, the calendar advances by exactly one second on the TICKS-th reference pulse counted since the stop bit was cleared, and on every TICKS-th pulse after that.
- R5: While the stop bit (0x20 bit 0) is set, the calendar holds its value whatever the reference pulses do.
- R6: Seconds roll from 59 to 0 and carry into minutes. Minutes roll from 59 to 0 and carry into hours. Hours roll from 23 to 0 and carry into the day. On each day carry, the weekday steps from 6 back to 0.
- R7: Day of month rolls to 1 after the last day of the month: 30 days for months 4, 6, 9 and 11, 31 for the other months except 2. Month rolls from 12 to 1 and carries into the year, and the year wraps from 99 to 0.
- R8: February has 29 days when the year is a multiple of 4 and not 0. Otherwise it has 28 days, so year 0 is treated as a common year.
- R9: Every field that a tick changes takes its new value on the same clock edge as the seconds field.
- R10: Alarm arming register 0x7c: bit 0 enables the alarm, and bits 1 to 7 select the fields year, month, day of month, weekday, hour, minute and second, in that order. On a tick whose new time equals the alarm bank in every selected field, status bit 4 is set. irq equals status bit 4 AND the enable bit.
- R11: Fields whose select bit is 0 do not block an alarm match.
- R12: Writing 1 to status bit 4 clears the pending flag. Writing 0 to the arming register forces irq low.
- R13: The 3-bit glitch-filter field at 0x2c, bits 2:0, is writable at all times and reads back what was written.
- R14: With enable bit 0 clear, a matching tick leaves status bit 4 at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_en | input | 1 | One-cycle pulse per reference clock period |
| reg_addr | input | 8 | Byte address of the register access |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| irq | output | 1 | Alarm interrupt |

## Verification
A register write takes effect at the clock edge that samples reg_we, and reads are combinational. The bench therefore drives at one falling edge and reads back at the next. A calendar advance, and any alarm flag it raises, appears at the same edge that samples the TICKS-th reference pulse, because both come from a single register stage. The bench counts pulses exactly, checks one pulse short of the boundary, and checks again after the final pulse, so both the early and the late case are tested. The pending flag and irq update in the same cycle as the time fields, so they are checked in the same read.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int NUM_FIELDS = 7;
    localparam int UNLOCK_STEPS = 7;

    localparam logic [7:0] ADDR_UNLOCK_FIRST = 8'h04;
    localparam logic [7:0] ADDR_UNLOCK_LAST  = 8'h1c;
    localparam logic [7:0] ADDR_RUNCTL       = 8'h20;
    localparam logic [7:0] ADDR_FILTER       = 8'h2c;
    localparam logic [7:0] ADDR_STATUS       = 8'h30;
    localparam logic [7:0] ADDR_ARM          = 8'h7c;
    localparam int PEND_BIT = 4;

    typedef struct packed {
        logic [6:0] year;
        logic [3:0] mon;
        logic [4:0] mday;
        logic [2:0] wday;
        logic [4:0] hour;
        logic [5:0] min;
        logic [5:0] sec;
    } caltime_t;

    localparam caltime_t TIME_RESET = '{year: 7'd0, mon: 4'd1, mday: 5'd1, wday: 3'd0,
                                        hour: 5'd0, min: 6'd0, sec: 6'd0};

    function automatic logic [7:0] unlock_key(input logic [2:0] step);
        case (step)
            3'd0:    return 8'hc6;
            3'd1:    return 8'h9a;
            3'd2:    return 8'h59;
            3'd3:    return 8'ha3;
            3'd4:    return 8'h57;
            3'd5:    return 8'h67;
            default: return 8'hd2;
        endcase
    endfunction

    function automatic logic leap_year(input logic [6:0] yr);
        return (yr[1:0] == 2'b00) && (yr != 7'd0);
    endfunction

    function automatic logic [4:0] month_len(input logic [3:0] mon, input logic [6:0] yr);
        case (mon)
            4'd2:                    return leap_year(yr) ? 5'd29 : 5'd28;
            4'd4, 4'd6, 4'd9, 4'd11: return 5'd30;
            default:                 return 5'd31;
        endcase
    endfunction

    function automatic caltime_t step_second(input caltime_t t);
        caltime_t n = t;
        if (t.sec >= 6'd59) begin
            n.sec = 6'd0;
            if (t.min >= 6'd59) begin
                n.min = 6'd0;
                if (t.hour >= 5'd23) begin
                    n.hour = 5'd0;
                    n.wday = (t.wday >= 3'd6) ? 3'd0 : t.wday + 3'd1;
                    if (t.mday >= month_len(t.mon, t.year)) begin
                        n.mday = 5'd1;
                        if (t.mon >= 4'd12) begin
                            n.mon  = 4'd1;
                            n.year = (t.year >= 7'd99) ? 7'd0 : t.year + 7'd1;
                        end else begin
                            n.mon = t.mon + 4'd1;
                        end
                    end else begin
                        n.mday = t.mday + 5'd1;
                    end
                end else begin
                    n.hour = t.hour + 5'd1;
                end
            end else begin
                n.min = t.min + 6'd1;
            end
        end else begin
            n.sec = t.sec + 6'd1;
        end
        return n;
    endfunction

    function automatic logic [6:0] field_get(input caltime_t t, input logic [2:0] f);
        case (f)
            3'd0:    return t.year;
            3'd1:    return {3'b0, t.mon};
            3'd2:    return {2'b0, t.mday};
            3'd3:    return {4'b0, t.wday};
            3'd4:    return {2'b0, t.hour};
            3'd5:    return {1'b0, t.min};
            default: return {1'b0, t.sec};
        endcase
    endfunction

    function automatic caltime_t field_put(input caltime_t t, input logic [2:0] f,
                                           input logic [6:0] v);
        caltime_t n = t;
        case (f)
            3'd0:    n.year = v;
            3'd1:    n.mon  = v[3:0];
            3'd2:    n.mday = v[4:0];
            3'd3:    n.wday = v[2:0];
            3'd4:    n.hour = v[4:0];
            3'd5:    n.min  = v[5:0];
            default: n.sec  = v[5:0];
        endcase
        return n;
    endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
    parameter int TICKS = 32768
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic ref_en,
    output logic tick
);
    localparam int CW = (TICKS > 1) ? $clog2(TICKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (ref_en) begin
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
        end
    end

    assign tick = run && ref_en && (cnt == LAST);

    generate
        if (TICKS > 1) begin : g_spacing
            // R4: two ticks are never adjacent when a second spans several pulses
            a_r4_tick_spacing: assert property (@(posedge clk) disable iff (rst)
                tick |=> !tick);
        end
    endgenerate

endmodule

// File: rtl/rtc_unlock.sv
module rtc_unlock
    import rtc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       we,
    input  logic [7:0] addr,
    input  logic [7:0] wdata,
    output logic       unlocked
);
    logic [2:0] step;
    logic       in_window;
    logic       key_ok;
    logic       first_ok;
    logic [7:0] want_addr;

    assign want_addr = ADDR_UNLOCK_FIRST + {3'b000, step, 2'b00};
    assign in_window = (addr >= ADDR_UNLOCK_FIRST) && (addr <= ADDR_UNLOCK_LAST)
                       && (addr[1:0] == 2'b00);
    assign key_ok    = (addr == want_addr) && (wdata == unlock_key(step));
    assign first_ok  = (addr == ADDR_UNLOCK_FIRST) && (wdata == unlock_key(3'd0));

    always_ff @(posedge clk) begin
        if (rst) begin
            step     <= 3'd0;
            unlocked <= 1'b0;
        end else if (we && in_window && !unlocked) begin
            if (key_ok) begin
                if (step == 3'(UNLOCK_STEPS - 1)) begin
                    unlocked <= 1'b1;
                    step     <= 3'd0;
                end else begin
                    step <= step + 3'd1;
                end
            end else begin
                step <= first_ok ? 3'd1 : 3'd0;
            end
        end
    end

    // R3: unlocking is always caused by the final key write
    a_r3_last_key: assert property (@(posedge clk) disable iff (rst)
        $rose(unlocked) |-> $past(we && addr == ADDR_UNLOCK_LAST && wdata == unlock_key(3'd6)));

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
    import rtc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       adv,
    input  logic       ld,
    input  logic [2:0] ld_fld,
    input  logic [6:0] ld_val,
    output caltime_t   now,
    output caltime_t   nxt
);
    assign nxt = step_second(now);

    always_ff @(posedge clk) begin
        if (rst)      now <= TIME_RESET;
        else if (ld)  now <= field_put(now, ld_fld, ld_val);
        else if (adv) now <= nxt;
    end

    // R4: the time moves only on a tick or a software load
    a_r4_only_on_tick: assert property (@(posedge clk) disable iff (rst)
        !$stable(now) |-> $past(adv || ld));

    // R9: on a tick, any field change is accompanied by a seconds change
    a_r9_fields_together: assert property (@(posedge clk) disable iff (rst)
        (!$stable(now) && !$past(ld)) |-> !$stable(now.sec));

endmodule

// File: rtl/cal_rtc_top.sv
module cal_rtc_top
    import rtc_pkg::*;
#(
    parameter int TICKS = 32768
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        ref_en,
    input  logic [7:0]  reg_addr,
    input  logic        reg_we,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        irq
);
    logic       unlocked;
    logic       stop;
    logic [7:0] arm;
    logic       pend;
    logic [2:0] filt;
    caltime_t   alarm;
    caltime_t   now;
    caltime_t   nxt;
    logic       tick;

    logic       bank_hit;
    logic       bank_sel;
    logic [2:0] fld;
    logic       time_ld;
    logic       alarm_ld;
    logic       prot_ok;
    logic       match;

    logic unused_wdata;
    assign unused_wdata = ^reg_wdata[31:8];

    assign bank_hit = (reg_addr[7:6] == 2'b01) && (reg_addr[1:0] == 2'b00)
                      && (reg_addr[4:2] != 3'd7);
    assign bank_sel = reg_addr[5];
    assign fld      = reg_addr[4:2];
    assign prot_ok  = reg_we && unlocked;
    assign time_ld  = prot_ok && bank_hit && !bank_sel;
    assign alarm_ld = prot_ok && bank_hit && bank_sel;

    rtc_unlock u_unlock (
        .clk      (clk),
        .rst      (rst),
        .we       (reg_we),
        .addr     (reg_addr),
        .wdata    (reg_wdata[7:0]),
        .unlocked (unlocked)
    );

    rtc_prescaler #(.TICKS(TICKS)) u_presc (
        .clk    (clk),
        .rst    (rst),
        .run    (!stop),
        .ref_en (ref_en),
        .tick   (tick)
    );

    rtc_calendar u_cal (
        .clk    (clk),
        .rst    (rst),
        .adv    (tick),
        .ld     (time_ld),
        .ld_fld (fld),
        .ld_val (reg_wdata[6:0]),
        .now    (now),
        .nxt    (nxt)
    );

    always_comb begin
        match = 1'b1;
        for (int f = 0; f < NUM_FIELDS; f++) begin
            if (arm[f+1] && (field_get(nxt, 3'(f)) != field_get(alarm, 3'(f))))
                match = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stop  <= 1'b1;
            arm   <= 8'h00;
            pend  <= 1'b0;
            filt  <= 3'd0;
            alarm <= TIME_RESET;
        end else begin
            if (prot_ok && reg_addr == ADDR_RUNCTL) stop <= reg_wdata[0];
            if (prot_ok && reg_addr == ADDR_ARM)    arm  <= reg_wdata[7:0];
            if (reg_we && reg_addr == ADDR_FILTER)  filt <= reg_wdata[2:0];
            if (alarm_ld) alarm <= field_put(alarm, fld, reg_wdata[6:0]);
            if (tick && !time_ld && arm[0] && match)
                pend <= 1'b1;
            else if (reg_we && reg_addr == ADDR_STATUS && reg_wdata[PEND_BIT])
                pend <= 1'b0;
        end
    end

    assign irq = pend && arm[0];

    always_comb begin
        reg_rdata = 32'h0;
        if (bank_hit)
            reg_rdata = {25'h0, field_get(bank_sel ? alarm : now, fld)};
        else if (reg_addr == ADDR_RUNCTL)
            reg_rdata = {31'h0, stop};
        else if (reg_addr == ADDR_FILTER)
            reg_rdata = {29'h0, filt};
        else if (reg_addr == ADDR_STATUS)
            reg_rdata = 32'(pend) << PEND_BIT;
        else if (reg_addr == ADDR_ARM)
            reg_rdata = {24'h0, arm};
    end

    // R5: while stopped, only a software load can change the time
    a_r5_frozen: assert property (@(posedge clk) disable iff (rst)
        ($past(stop) && !$past(time_ld)) |-> $stable(now));

    // R14: the pending flag is only raised while the alarm is enabled
    a_r14_needs_enable: assert property (@(posedge clk) disable iff (rst)
        $rose(pend) |-> $past(arm[0]));

    // R2: protected registers stay put while locked
    a_r2_locked_arm: assert property (@(posedge clk) disable iff (rst)
        $past(!unlocked) |-> $stable(arm) && $stable(alarm));

    // R10: irq never rises without a tick or arming write the cycle before
    a_r10_irq_source: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(tick || reg_we));

endmodule

// File: tb/test_cal_rtc_top.sv
module test_cal_rtc_top;

    localparam int CLK_PERIOD = 10;
    localparam int TICKS = 4;
    localparam int NVEC = 11;

    // each vector: year, month, mday, wday, hour, min, sec as bytes
    localparam logic [55:0] V_IN [NVEC] = '{
        {8'd23, 8'd5,  8'd10, 8'd3, 8'd12, 8'd30, 8'd15},
        {8'd23, 8'd5,  8'd10, 8'd3, 8'd12, 8'd30, 8'd59},
        {8'd23, 8'd5,  8'd10, 8'd3, 8'd23, 8'd59, 8'd59},
        {8'd23, 8'd4,  8'd30, 8'd6, 8'd23, 8'd59, 8'd59},
        {8'd23, 8'd12, 8'd31, 8'd2, 8'd23, 8'd59, 8'd59},
        {8'd99, 8'd12, 8'd31, 8'd5, 8'd23, 8'd59, 8'd59},
        {8'd24, 8'd2,  8'd28, 8'd1, 8'd23, 8'd59, 8'd59},
        {8'd24, 8'd2,  8'd29, 8'd2, 8'd23, 8'd59, 8'd59},
        {8'd23, 8'd2,  8'd28, 8'd1, 8'd23, 8'd59, 8'd59},
        {8'd0,  8'd2,  8'd28, 8'd1, 8'd23, 8'd59, 8'd59},
        {8'd23, 8'd1,  8'd31, 8'd0, 8'd23, 8'd59, 8'd59}
    };
    localparam logic [55:0] V_EXP [NVEC] = '{
        {8'd23, 8'd5,  8'd10, 8'd3, 8'd12, 8'd30, 8'd16},
        {8'd23, 8'd5,  8'd10, 8'd3, 8'd12, 8'd31, 8'd0},
        {8'd23, 8'd5,  8'd11, 8'd4, 8'd0,  8'd0,  8'd0},
        {8'd23, 8'd5,  8'd1,  8'd0, 8'd0,  8'd0,  8'd0},
        {8'd24, 8'd1,  8'd1,  8'd3, 8'd0,  8'd0,  8'd0},
        {8'd0,  8'd1,  8'd1,  8'd6, 8'd0,  8'd0,  8'd0},
        {8'd24, 8'd2,  8'd29, 8'd2, 8'd0,  8'd0,  8'd0},
        {8'd24, 8'd3,  8'd1,  8'd3, 8'd0,  8'd0,  8'd0},
        {8'd23, 8'd3,  8'd1,  8'd2, 8'd0,  8'd0,  8'd0},
        {8'd0,  8'd3,  8'd1,  8'd2, 8'd0,  8'd0,  8'd0},
        {8'd23, 8'd2,  8'd1,  8'd1, 8'd0,  8'd0,  8'd0}
    };
    localparam string VREQ [NVEC] = '{"R6", "R6", "R6", "R7", "R7", "R7",
                                       "R8", "R8", "R8", "R8", "R7"};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ref_en = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = 32'h0;
    logic [31:0] reg_rdata;
    logic        irq;

    int checks = 0;
    int failures = 0;
    logic [31:0] rv;

    always #(CLK_PERIOD / 2) clk = ~clk;

    cal_rtc_top #(.TICKS(TICKS)) i_cal_rtc_top (
        .clk       (clk),
        .rst       (rst),
        .ref_en    (ref_en),
        .reg_addr  (reg_addr),
        .reg_we    (reg_we),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq       (irq)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) ref_en = 1'b1;
            @(negedge clk) ref_en = 1'b0;
        end
    endtask

    task automatic set_time(input logic [55:0] v);
        for (int f = 0; f < 7; f++) wr(8'h40 + 8'(4 * f), {24'h0, v[55 - 8 * f -: 8]});
    endtask

    task automatic check_time(input string req, input logic [55:0] v);
        for (int f = 0; f < 7; f++) begin
            rd(8'h40 + 8'(4 * f), rv);
            check(req, $sformatf("time field %0d", f), rv, {24'h0, v[55 - 8 * f -: 8]});
        end
    endtask

    task automatic unlock_seq(input logic [7:0] bad_at);
        logic [7:0] keys [7] = '{8'hc6, 8'h9a, 8'h59, 8'ha3, 8'h57, 8'h67, 8'hd2};
        for (int s = 0; s < 7; s++) begin
            if (8'(s) == bad_at) wr(8'h04 + 8'(4 * s), 32'h00);
            else                 wr(8'h04 + 8'(4 * s), {24'h0, keys[s]});
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        failures++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check_time("R1", {8'd0, 8'd1, 8'd1, 8'd0, 8'd0, 8'd0, 8'd0});
        rd(8'h20, rv); check("R1", "run control", rv, 32'h1);
        rd(8'h30, rv); check("R1", "status", rv, 32'h0);
        rd(8'h2c, rv); check("R1", "filter", rv, 32'h0);
        check("R1", "irq", {31'h0, irq}, 32'h0);

        // R13 filter field always writable, 3 bits
        wr(8'h2c, 32'h5);  rd(8'h2c, rv); check("R13", "filter 5", rv, 32'h5);
        wr(8'h2c, 32'hff); rd(8'h2c, rv); check("R13", "filter masked", rv, 32'h7);
        wr(8'h2c, 32'h0);  rd(8'h2c, rv); check("R13", "filter 0", rv, 32'h0);

        // R2 locked writes ignored
        wr(8'h58, 32'd42); rd(8'h58, rv); check("R2", "sec locked", rv, 32'd0);
        wr(8'h20, 32'h0);  rd(8'h20, rv); check("R2", "ctl locked", rv, 32'h1);
        wr(8'h7c, 32'hff); rd(8'h7c, rv); check("R2", "arm locked", rv, 32'h0);
        wr(8'h78, 32'd9);  rd(8'h78, rv); check("R2", "alarm sec locked", rv, 32'd0);

        // R3 a wrong key at step 3 restarts the sequence
        unlock_seq(8'd3);
        wr(8'h58, 32'd42); rd(8'h58, rv); check("R3", "sec after bad sequence", rv, 32'd0);
        unlock_seq(8'hff);
        wr(8'h58, 32'd42); rd(8'h58, rv); check("R3", "sec after good sequence", rv, 32'd42);

        // R6 R7 R8 rollover vectors
        for (int v = 0; v < NVEC; v++) begin
            wr(8'h20, 32'h1);
            set_time(V_IN[v]);
            wr(8'h20, 32'h0);
            pulses(TICKS);
            wr(8'h20, 32'h1);
            check_time(VREQ[v], V_EXP[v]);
        end

        // R5 stopped clock holds, R4 prescaler boundary
        wr(8'h58, 32'd10);
        pulses(3 * TICKS);
        rd(8'h58, rv); check("R5", "sec while stopped", rv, 32'd10);
        wr(8'h20, 32'h0);
        pulses(TICKS - 1);
        rd(8'h58, rv); check("R4", "sec one pulse short", rv, 32'd10);
        pulses(1);
        rd(8'h58, rv); check("R4", "sec after full second", rv, 32'd11);
        pulses(TICKS);
        rd(8'h58, rv); check("R4", "sec after second tick", rv, 32'd12);
        wr(8'h20, 32'h1);

        // R10 full-field alarm
        set_time({8'd23, 8'd5, 8'd10, 8'd3, 8'd12, 8'd30, 8'd15});
        for (int f = 0; f < 7; f++)
            wr(8'h60 + 8'(4 * f), {24'h0, 8'(f == 0 ? 23 : f == 1 ? 5 : f == 2 ? 10 :
                                            f == 3 ? 3 : f == 4 ? 12 : f == 5 ? 30 : 17)});
        wr(8'h7c, 32'hff);
        wr(8'h20, 32'h0);
        pulses(TICKS);
        rd(8'h30, rv); check("R10", "status before match", rv, 32'h0);
        check("R10", "irq before match", {31'h0, irq}, 32'h0);
        pulses(TICKS);
        rd(8'h30, rv); check("R10", "status on match", rv, 32'h10);
        check("R10", "irq on match", {31'h0, irq}, 32'h1);

        // R12 disarm masks irq, write 1 clears
        wr(8'h7c, 32'h0);
        check("R12", "irq after disarm", {31'h0, irq}, 32'h0);
        rd(8'h30, rv); check("R12", "status kept", rv, 32'h10);
        wr(8'h30, 32'h10);
        rd(8'h30, rv); check("R12", "status cleared", rv, 32'h0);

        // R11 only the seconds field selected; minute mismatch ignored
        wr(8'h74, 32'd45);
        wr(8'h78, 32'd20);
        wr(8'h7c, 32'h81);
        pulses(2 * TICKS);
        rd(8'h58, rv); check("R11", "sec at 19", rv, 32'd19);
        rd(8'h30, rv); check("R11", "status at 19", rv, 32'h0);
        pulses(TICKS);
        rd(8'h30, rv); check("R11", "status at 20", rv, 32'h10);
        check("R11", "irq at 20", {31'h0, irq}, 32'h1);
        wr(8'h30, 32'h10);

        // R14 selected but not enabled
        wr(8'h78, 32'd22);
        wr(8'h7c, 32'h80);
        pulses(2 * TICKS);
        rd(8'h58, rv); check("R14", "sec at 22", rv, 32'd22);
        rd(8'h30, rv); check("R14", "status disabled", rv, 32'h0);
        check("R14", "irq disabled", {31'h0, irq}, 32'h0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule